// File: doc/BRIEF.md
# Configurable UART Serial Frame Engine

This block sends and receives asynchronous serial characters on a single transmit line and a single receive line. Software-visible configuration is presented as three byte-wide control inputs plus a baud divisor input. Together they set the data length (five to eight bits), an optional parity bit of either sense, one or two stop bits and the bit period. Characters enter through a one-deep transmit holding register with a valid/ready handshake. Received characters are presented on a data output with a full flag, and are consumed with a one-cycle read pulse.

A nine-bit status vector reports the transmitter state, the receiver state and four sticky error conditions: overrun, framing, parity and break. A one-cycle error-clear pulse clears overrun, framing and parity. A clear bit in the control byte returns the transmitter, the receiver and every flag to their reset state. Unused high bits of a short received character read as zero.

Top module: `uart_frame_engine`

## Requirements
- R1: `ext_reg[1:0]` selects the data length: 0 gives 8 bits, 1 gives 5, 2 gives 6 and 3 gives 7. Data is sent least significant bit first. Transmit bits above the length are not sent. `rx_data` bits above the length read 0.
- R2: `ext_reg[4]`=1 inserts a parity bit after the data. `ext_reg[3]`=1 selects odd parity (data ones plus parity bit is odd), and 0 selects even parity.
- R3: `mode_reg[3]`=1 sends two stop bits (line high), and 0 sends one.
- R4: Every transmitted bit, the start bit (line low) included, lasts exactly `baud_reg`+1 clock cycles.
- R5: `status` bit 0 is TX idle, bit 1 is TX holding empty, bit 2 is RX data full, bit 3 is overrun, bit 4 is framing error, bit 5 is parity error and bit 8 is break. Bits 6 and 7 read 0. After reset, `status` is 9'h003.
- R6: A one-cycle `err_clr` pulse clears status bits 3, 4 and 5 in the following cycle. It leaves break, `rx_valid` and `rx_data` unchanged.
- R7: `ctrl_reg[0]` enables the transmitter. While it is 0, `tx_ready` is 0 and `tx_valid` is ignored. `ctrl_reg[1]` enables the receiver. While it is 0, frames on `rxd` are ignored.
- R8: While `ctrl_reg[7]` is 1, the transmitter and receiver are held idle: `txd`=1, `status` bits 0 and 1 are 1, and `rx_valid` and all error flags are 0. A frame in progress is abandoned.
- R9: The receiver samples each bit at the middle of its period. A start bit that is back high at its middle is discarded, and the receiver then waits for the next falling edge.
- R10: A received frame whose data, parity and stop bits are all 0 sets break (bit 8) together with framing error.
- R11: TX idle is 1 only when the shift register is idle and the holding register is empty. `txd` is 1 whenever TX idle is 1.
- R12: If a frame completes while `rx_valid` is 1, overrun is set and `rx_data` keeps the earlier character.
- R13: When parity is enabled, a received parity bit that does not match the selected sense sets parity error. The character is still delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 8 | Mode byte, bit 3 selects two stop bits |
| ext_reg | input | 8 | Format byte: bits 1:0 length code, bit 3 odd parity, bit 4 parity enable |
| ctrl_reg | input | 8 | Control byte: bit 0 TX enable, bit 1 RX enable, bit 7 clear |
| baud_reg | input | DIV_W | Bit period minus one, in clocks |
| err_clr | input | 1 | Pulse clearing overrun, framing and parity flags |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Holding register free and transmitter enabled |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | Received character waiting |
| rx_read | input | 1 | Pulse consuming the received character |
| status | output | 9 | Status flags |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor and a two-stage receive synchronizer. Divisors between 3 and 15 are applied at run time, so every length, parity and stop-bit combination fits in a few hundred cycles. This also puts the tight half-period sampling of the smallest divisor within reach. The transmit line is compared cycle by cycle against a frame built in the bench, and the same frame is looped back to the receiver. The bench also drives hand-made frames with wrong parity, a low stop bit, all zeros or a glitch start, which reach the error, break and false-start paths.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP,
        PH_LINGER
    } phase_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_cfg_t;

    // status vector positions
    localparam int ST_TX_IDLE  = 0;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_RX_FULL  = 2;
    localparam int ST_OVR      = 3;
    localparam int ST_FRM      = 4;
    localparam int ST_PAR      = 5;
    localparam int ST_BRK      = 8;
    localparam int ST_W        = 9;

    // control byte positions
    localparam int MODE_TWO_STOP = 3;
    localparam int EXT_PAR_ODD   = 3;
    localparam int EXT_PAR_EN    = 4;
    localparam int CTL_TX_EN     = 0;
    localparam int CTL_RX_EN     = 1;
    localparam int CTL_CLEAR     = 7;

    // index of the last data bit for a length code (0 -> 8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return (code == 2'd0) ? 3'd7 : ({1'b0, code} + 3'd3);
    endfunction

    function automatic logic [7:0] data_mask(input logic [1:0] code);
        return 8'hFF >> (3'd7 - last_bit_idx(code));
    endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tx_en,
    input  frame_cfg_t       cfg,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             hold_empty,
    output logic             line_idle,
    output logic             txd
);

    typedef struct packed {
        phase_e           phase;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bit_idx;
        logic             stop_idx;
        logic [7:0]       shreg;
        logic             par_bit;
        logic [7:0]       hold;
        logic             hold_full;
        logic             txd;
    } tx_state_t;

    localparam tx_state_t TX_RST = '{
        phase: PH_IDLE, cnt: '0, bit_idx: 3'd0, stop_idx: 1'b0,
        shreg: 8'd0, par_bit: 1'b0, hold: 8'd0, hold_full: 1'b0, txd: 1'b1
    };

    tx_state_t s_d, s_q;
    logic      tick;
    logic      accept;
    logic [7:0] masked;

    always_comb begin
        s_d    = s_q;
        tick   = (s_q.cnt == div);
        accept = wr_valid && tx_en && !s_q.hold_full;
        masked = s_q.hold & data_mask(cfg.len_code);
        s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;

        case (s_q.phase)
            PH_IDLE: begin
                s_d.cnt = '0;
                s_d.txd = 1'b1;
                if (s_q.hold_full && tx_en) begin
                    s_d.phase     = PH_START;
                    s_d.shreg     = masked;
                    s_d.par_bit   = (^masked) ^ cfg.par_odd;
                    s_d.hold_full = 1'b0;
                    s_d.txd       = 1'b0;
                end
            end
            PH_START: begin
                if (tick) begin
                    s_d.phase   = PH_DATA;
                    s_d.bit_idx = 3'd0;
                    s_d.txd     = s_q.shreg[0];
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (s_q.bit_idx == last_bit_idx(cfg.len_code)) begin
                        if (cfg.par_en) begin
                            s_d.phase = PH_PARITY;
                            s_d.txd   = s_q.par_bit;
                        end else begin
                            s_d.phase    = PH_STOP;
                            s_d.stop_idx = 1'b0;
                            s_d.txd      = 1'b1;
                        end
                    end else begin
                        s_d.bit_idx = s_q.bit_idx + 3'd1;
                        s_d.shreg   = s_q.shreg >> 1;
                        s_d.txd     = s_q.shreg[1];
                    end
                end
            end
            PH_PARITY: begin
                if (tick) begin
                    s_d.phase    = PH_STOP;
                    s_d.stop_idx = 1'b0;
                    s_d.txd      = 1'b1;
                end
            end
            PH_STOP: begin
                s_d.txd = 1'b1;
                if (tick) begin
                    if (cfg.two_stop && !s_q.stop_idx) begin
                        s_d.stop_idx = 1'b1;
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.txd   = 1'b1;
            end
        endcase

        if (accept) begin
            s_d.hold      = wr_data;
            s_d.hold_full = 1'b1;
        end

        if (clr) begin
            s_d = TX_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= TX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ready   = tx_en && !s_q.hold_full;
    assign hold_empty = !s_q.hold_full;
    assign line_idle  = (s_q.phase == PH_IDLE) && !s_q.hold_full;
    assign txd        = s_q.txd;

    AST_TX_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> txd); // R11

    AST_TX_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !clr) |=> !wr_ready); // R7

    AST_TX_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (line_idle && hold_empty)); // R8

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rx_en,
    input  frame_cfg_t       cfg,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd_s,
    input  logic             rd_ack,
    input  logic             err_clr,
    output logic [7:0]       rd_data,
    output logic             rd_full,
    output logic             ovr,
    output logic             frm,
    output logic             per,
    output logic             brk
);

    typedef struct packed {
        phase_e           phase;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bit_idx;
        logic             stop_idx;
        logic [7:0]       shreg;
        logic             par_seen;
        logic             stop_bad;
        logic             all_zero;
        logic [7:0]       data;
        logic             full;
        logic             ovr;
        logic             frm;
        logic             per;
        logic             brk;
    } rx_state_t;

    localparam rx_state_t RX_RST = '{
        phase: PH_IDLE, cnt: '0, bit_idx: 3'd0, stop_idx: 1'b0, shreg: 8'd0,
        par_seen: 1'b0, stop_bad: 1'b0, all_zero: 1'b0, data: 8'd0,
        full: 1'b0, ovr: 1'b0, frm: 1'b0, per: 1'b0, brk: 1'b0
    };

    rx_state_t s_d, s_q;
    logic      tick;
    logic      mid;
    logic      finish;

    always_comb begin
        s_d    = s_q;
        tick   = (s_q.cnt == div);
        mid    = (s_q.cnt == (div >> 1));
        finish = 1'b0;
        s_d.cnt = s_q.cnt + 1'b1;

        if (rd_ack) begin
            s_d.full = 1'b0;
        end

        case (s_q.phase)
            PH_IDLE: begin
                s_d.cnt = '0;
                if (rx_en && !rxd_s) begin
                    s_d.phase = PH_START;
                end
            end
            PH_START: begin
                if (mid) begin
                    s_d.cnt = '0;
                    if (!rxd_s) begin
                        s_d.phase    = PH_DATA;
                        s_d.bit_idx  = 3'd0;
                        s_d.shreg    = 8'd0;
                        s_d.par_seen = 1'b0;
                        s_d.stop_bad = 1'b0;
                        s_d.all_zero = 1'b1;
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end
            end
            PH_DATA: begin
                if (tick) begin
                    s_d.cnt                = '0;
                    s_d.shreg[s_q.bit_idx] = rxd_s;
                    s_d.all_zero           = s_q.all_zero && !rxd_s;
                    if (s_q.bit_idx == last_bit_idx(cfg.len_code)) begin
                        s_d.phase    = cfg.par_en ? PH_PARITY : PH_STOP;
                        s_d.stop_idx = 1'b0;
                    end else begin
                        s_d.bit_idx = s_q.bit_idx + 3'd1;
                    end
                end
            end
            PH_PARITY: begin
                if (tick) begin
                    s_d.cnt      = '0;
                    s_d.par_seen = rxd_s;
                    s_d.all_zero = s_q.all_zero && !rxd_s;
                    s_d.phase    = PH_STOP;
                    s_d.stop_idx = 1'b0;
                end
            end
            PH_STOP: begin
                if (tick) begin
                    s_d.cnt      = '0;
                    s_d.stop_bad = s_q.stop_bad || !rxd_s;
                    s_d.all_zero = s_q.all_zero && !rxd_s;
                    if (cfg.two_stop && !s_q.stop_idx) begin
                        s_d.stop_idx = 1'b1;
                    end else begin
                        finish    = 1'b1;
                        s_d.phase = rxd_s ? PH_IDLE : PH_LINGER;
                    end
                end
            end
            PH_LINGER: begin
                s_d.cnt = '0;
                if (rxd_s) begin
                    s_d.phase = PH_IDLE;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase

        if (finish) begin
            if (s_d.full) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.data = s_d.shreg;
                s_d.full = 1'b1;
                s_d.frm  = s_q.frm || s_d.stop_bad;
                s_d.per  = s_q.per || (cfg.par_en &&
                           (s_d.par_seen != ((^s_d.shreg) ^ cfg.par_odd)));
            end
            s_d.brk = s_q.brk || s_d.all_zero;
        end

        if (!rx_en) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end

        if (err_clr) begin
            s_d.ovr = 1'b0;
            s_d.frm = 1'b0;
            s_d.per = 1'b0;
        end

        if (clr) begin
            s_d = RX_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.data;
    assign rd_full = s_q.full;
    assign ovr     = s_q.ovr;
    assign frm     = s_q.frm;
    assign per     = s_q.per;
    assign brk     = s_q.brk;

    AST_RX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_full && !rd_ack && !clr) |=> (rd_full && $stable(rd_data))); // R12

    AST_RX_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rd_full)); // R12

    AST_RX_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !(ovr || frm || per)); // R6

    AST_RX_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rd_full && !brk)); // R8

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       mode_reg,
    input  logic [7:0]       ext_reg,
    input  logic [7:0]       ctrl_reg,
    input  logic [DIV_W-1:0] baud_reg,
    input  logic             err_clr,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_read,
    output logic [ST_W-1:0]  status,
    input  logic             rxd,
    output logic             txd
);

    frame_cfg_t             cfg;
    logic                   clr;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;
    logic                   hold_empty, line_idle;
    logic                   ovr, frm, per, brk;
    logic                   unused_bits;

    assign cfg = '{
        len_code: ext_reg[1:0],
        par_en:   ext_reg[EXT_PAR_EN],
        par_odd:  ext_reg[EXT_PAR_ODD],
        two_stop: mode_reg[MODE_TWO_STOP]
    };
    assign clr = ctrl_reg[CTL_CLEAR];
    assign unused_bits = ^{mode_reg[7:4], mode_reg[2:0], ext_reg[7:5], ext_reg[2],
                           ctrl_reg[6:2]};

    // receive line synchronizer
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            logic stage_d;
            if (g == 0) begin : g_first
                assign stage_d = rxd;
            end else begin : g_next
                assign stage_d = sync_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b1;
                end else begin
                    sync_q[g] <= stage_d;
                end
            end
        end
    endgenerate
    assign rxd_s = sync_q[SYNC_STAGES-1];

    uart_fe_tx #(.DIV_W(DIV_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .tx_en      (ctrl_reg[CTL_TX_EN]),
        .cfg        (cfg),
        .div        (baud_reg),
        .wr_data    (tx_data),
        .wr_valid   (tx_valid),
        .wr_ready   (tx_ready),
        .hold_empty (hold_empty),
        .line_idle  (line_idle),
        .txd        (txd)
    );

    uart_fe_rx #(.DIV_W(DIV_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .rx_en   (ctrl_reg[CTL_RX_EN]),
        .cfg     (cfg),
        .div     (baud_reg),
        .rxd_s   (rxd_s),
        .rd_ack  (rx_read),
        .err_clr (err_clr),
        .rd_data (rx_data),
        .rd_full (rx_valid),
        .ovr     (ovr),
        .frm     (frm),
        .per     (per),
        .brk     (brk)
    );

    always_comb begin
        status              = '0;
        status[ST_TX_IDLE]  = line_idle;
        status[ST_TX_EMPTY] = hold_empty;
        status[ST_RX_FULL]  = rx_valid;
        status[ST_OVR]      = ovr;
        status[ST_FRM]      = frm;
        status[ST_PAR]      = per;
        status[ST_BRK]      = brk;
    end

    AST_BRK_WITH_FRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_BRK]) |-> (status[ST_FRM] || $past(err_clr))); // R10

endmodule

// File: tb/uart_frame_engine_bench.sv
module uart_frame_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mode_reg = 8'h00;
    logic [7:0]  ext_reg = 8'h00;
    logic [7:0]  ctrl_reg = 8'h00;
    logic [15:0] baud_reg = 16'd3;
    logic        err_clr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_read = 1'b0;
    logic [8:0]  status;
    logic        txd;
    logic        bench_rxd = 1'b1;
    logic        loop_en = 1'b0;
    logic        rxd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign rxd = loop_en ? txd : bench_rxd;

    uart_frame_engine u_uart_frame_engine (
        .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .ext_reg(ext_reg),
        .ctrl_reg(ctrl_reg), .baud_reg(baud_reg), .err_clr(err_clr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
        .status(status), .rxd(rxd), .txd(txd)
    );

    // {len[1:0], par_en, odd, two_stop, 3'b0, div[7:0], data[7:0]}
    localparam int NV = 7;
    localparam logic [23:0] VECS [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 3'b0, 8'd3,  8'hA5},
        {2'd1, 1'b1, 1'b0, 1'b0, 3'b0, 8'd4,  8'hFD},
        {2'd2, 1'b1, 1'b1, 1'b1, 3'b0, 8'd5,  8'h2B},
        {2'd3, 1'b0, 1'b0, 1'b1, 3'b0, 8'd7,  8'hC3},
        {2'd0, 1'b1, 1'b1, 1'b0, 3'b0, 8'd9,  8'h80},
        {2'd1, 1'b1, 1'b0, 1'b1, 3'b0, 8'd3,  8'h00},
        {2'd0, 1'b1, 1'b0, 1'b0, 3'b0, 8'd15, 8'hFF}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [7:0] d, input logic [1:0] len,
                         input logic pe, input logic odd, input logic two,
                         output logic [15:0] f, output int n);
        int nb;
        logic p;
        nb = (len == 2'd0) ? 8 : int'(len) + 4;
        p  = odd;
        f  = '0;
        f[0] = 1'b0;
        n  = 1;
        for (int i = 0; i < nb; i++) begin
            f[n] = d[i];
            p    = p ^ d[i];
            n++;
        end
        if (pe) begin
            f[n] = p;
            n++;
        end
        f[n] = 1'b1;
        n++;
        if (two) begin
            f[n] = 1'b1;
            n++;
        end
    endtask

    task automatic set_fmt(input logic [1:0] len, input logic pe, input logic odd,
                           input logic two, input logic [15:0] div);
        ext_reg  = {3'b000, pe, odd, 1'b0, len};
        mode_reg = {4'b0000, two, 3'b000};
        baud_reg = div;
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic capture(input logic [15:0] f, input int n, input int p,
                           output int bad);
        int guard;
        bad   = 0;
        guard = 0;
        while (txd !== 1'b0 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 300) begin
            bad = 999;
        end else begin
            for (int j = 0; j < n * p; j++) begin
                if (txd !== f[j / p]) bad++;
                @(negedge clk);
            end
        end
    endtask

    task automatic drive_rx(input logic [15:0] f, input int n, input int p);
        for (int b = 0; b < n; b++) begin
            bench_rxd = f[b];
            repeat (p) @(negedge clk);
        end
        bench_rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic pulse_err_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R1..R13 run) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] f;
        int n;
        int bad;
        int lows;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(status == 9'h003, "R5 reset status", 32'(status), 32'h003);
        check(txd == 1'b1, "R11 reset line high", 32'(txd), 32'h1);
        check(rx_valid == 1'b0, "R5 reset rx empty", 32'(rx_valid), 32'h0);
        check(tx_ready == 1'b0, "R7 tx_ready low while disabled", 32'(tx_ready), 32'h0);

        // table-driven loopback frames
        ctrl_reg = 8'h03;
        loop_en  = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            logic [7:0]  expd;
            v = VECS[i];
            set_fmt(v[23:22], v[21], v[20], v[19], {8'h00, v[15:8]});
            build(v[7:0], v[23:22], v[21], v[20], v[19], f, n);
            expd = v[7:0] & ((v[23:22] == 2'd0) ? 8'hFF : (8'hFF >> (4 - v[23:22])));
            send_tx(v[7:0]);
            capture(f, n, int'(v[15:8]) + 1, bad);
            check(bad == 0, "R1 R2 R3 R4 tx waveform", 32'(bad), 32'h0);
            repeat (4) @(negedge clk);
            check(rx_valid && rx_data == expd, "R1 loopback data", {23'h0, rx_valid, rx_data},
                  {23'h0, 1'b1, expd});
            check(status[5:3] == 3'b000, "R13 no error on good frame", 32'(status[5:3]), 32'h0);
            check(status[0] == 1'b1, "R11 idle after frame", 32'(status[0]), 32'h1);
            pulse_read();
        end
        loop_en = 1'b0;

        // R11 idle flag with data waiting / shifting
        set_fmt(2'd0, 1'b0, 1'b0, 1'b0, 16'd7);
        send_tx(8'h5A);
        check(status[1:0] == 2'b00, "R11 holding full not idle", 32'(status[1:0]), 32'h0);
        @(negedge clk);
        check(status[1:0] == 2'b10, "R11 shifting not idle", 32'(status[1:0]), 32'h2);
        build(8'h5A, 2'd0, 1'b0, 1'b0, 1'b0, f, n);
        capture(f, n, 8, bad);
        check(bad == 0, "R4 frame P=8", 32'(bad), 32'h0);

        // R7 transmitter disabled
        ctrl_reg = 8'h02;
        @(negedge clk);
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        lows = 0;
        repeat (3) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        tx_valid = 1'b0;
        check(status[1] == 1'b1, "R7 tx_valid ignored when disabled", 32'(status[1]), 32'h1);
        ctrl_reg = 8'h03;
        repeat (30) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0, "R7 no frame from disabled offer", 32'(lows), 32'h0);

        // R7 receiver disabled
        ctrl_reg = 8'h01;
        build(8'h5A, 2'd0, 1'b0, 1'b0, 1'b0, f, n);
        @(negedge clk);
        drive_rx(f, n, 8);
        check(rx_valid == 1'b0, "R7 rx ignored when disabled", 32'(rx_valid), 32'h0);
        ctrl_reg = 8'h03;

        // R9 glitch start rejected, then good frame
        @(negedge clk);
        bench_rxd = 1'b0;
        @(negedge clk);
        bench_rxd = 1'b1;
        repeat (30) @(negedge clk);
        check(rx_valid == 1'b0 && status[4] == 1'b0, "R9 glitch rejected",
              {30'h0, rx_valid, status[4]}, 32'h0);
        build(8'h3C, 2'd0, 1'b0, 1'b0, 1'b0, f, n);
        drive_rx(f, n, 8);
        check(rx_valid && rx_data == 8'h3C, "R9 mid-bit decode", {23'h0, rx_valid, rx_data}, 32'h13C);
        pulse_read();

        // R13 parity error
        set_fmt(2'd0, 1'b1, 1'b0, 1'b0, 16'd7);
        build(8'h03, 2'd0, 1'b1, 1'b0, 1'b0, f, n);
        f[9] = ~f[9];
        @(negedge clk);
        drive_rx(f, n, 8);
        check(status[5] == 1'b1, "R13 parity error flagged", 32'(status[5]), 32'h1);
        check(rx_valid && rx_data == 8'h03, "R13 char still delivered",
              {23'h0, rx_valid, rx_data}, 32'h103);
        pulse_read();
        pulse_err_clr();
        check(status[5] == 1'b0, "R6 parity flag cleared", 32'(status[5]), 32'h0);

        // R12 overrun
        build(8'h11, 2'd0, 1'b1, 1'b0, 1'b0, f, n);
        @(negedge clk);
        drive_rx(f, n, 8);
        build(8'h22, 2'd0, 1'b1, 1'b0, 1'b0, f, n);
        drive_rx(f, n, 8);
        check(status[3] == 1'b1, "R12 overrun flagged", 32'(status[3]), 32'h1);
        check(rx_data == 8'h11, "R12 old char kept", 32'(rx_data), 32'h11);
        pulse_err_clr();
        check(status[3] == 1'b0, "R6 overrun cleared", 32'(status[3]), 32'h0);
        check(rx_valid && rx_data == 8'h11, "R6 data untouched by clear",
              {23'h0, rx_valid, rx_data}, 32'h111);
        pulse_read();

        // framing error without break
        set_fmt(2'd0, 1'b0, 1'b0, 1'b0, 16'd7);
        build(8'h55, 2'd0, 1'b0, 1'b0, 1'b0, f, n);
        f[9] = 1'b0;
        @(negedge clk);
        drive_rx(f, n, 8);
        check(status[4] == 1'b1 && status[8] == 1'b0, "R10 framing only, no break",
              {30'h0, status[8], status[4]}, 32'h1);
        pulse_read();
        pulse_err_clr();

        // R10 break
        f = '0;
        @(negedge clk);
        drive_rx(f, 10, 8);
        check(status[8] == 1'b1 && status[4] == 1'b1, "R10 break with framing",
              {30'h0, status[8], status[4]}, 32'h3);
        pulse_err_clr();
        check(status[8] == 1'b1 && status[4] == 1'b0, "R6 break survives error clear",
              {30'h0, status[8], status[4]}, 32'h2);

        // R8 clear bit
        @(negedge clk);
        ctrl_reg = 8'h83;
        @(negedge clk);
        ctrl_reg = 8'h03;
        check(status[8] == 1'b0 && rx_valid == 1'b0, "R8 clear empties receiver",
              {30'h0, status[8], rx_valid}, 32'h0);

        send_tx(8'hF0);
        repeat (12) @(negedge clk);
        ctrl_reg = 8'h83;
        @(negedge clk);
        check(txd == 1'b1 && status[1:0] == 2'b11, "R8 clear abandons tx frame",
              {29'h0, txd, status[1:0]}, 32'h7);
        ctrl_reg = 8'h03;
        lows = 0;
        repeat (40) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0, "R8 nothing sent after clear", 32'(lows), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule